// File: doc/BRIEF.md
# Scannable Fibonacci LFSR Keystream Core

This block is an 8-stage external-feedback shift register that produces one keystream bit per clock. The register uses the polynomial 1 + x^3 + x^8, so the new value of stage 0 is the XOR of stages 2 and 7. A build parameter can also XOR an external data bit into that feedback. A parallel seed load starts a new sequence. The key schedule and any output combining logic sit outside this block.

For manufacturing test, the eight stages and a 2-bit implementation-only counter form one serial scan chain of ten positions:

scan_in → stage 0 … stage 7 → counter bit 0 → counter bit 1 → scan_out

While scan is enabled the chain shifts one position per clock and the keystream sequence is frozen. The counter is not part of the cipher function. It runs freely in normal mode, so its bits never track the LFSR contents.

Top module: `lfsr_scan_top`

## Requirements
- R1: A synchronous active-high `rst` sets the stages to 8'h01 and the counter to 0. Immediately after reset, `keystream_bit` is 0 and `scan_out` is 0.
- R2: On every clock without `load`, stage i (1 ≤ i ≤ 7) takes the value stage i-1 held before the edge, and `keystream_bit` always shows stage 7. After a seed load, the following 7 clocks therefore present seed bits 6 down to 0 on `keystream_bit`.
- R3: In normal mode (`load` = 0, `scan_en` = 0), stage 0 takes stage 2 XOR stage 7 XOR `din`.
- R4: `load` = 1 writes `seed[i]` into stage i at the next edge, whatever the value of `scan_en`.
- R5: Chain positions 0 to 7 are stages 0 to 7, and positions 8 and 9 are counter bits 0 and 1. `scan_out` shows position 9. Ten scan clocks therefore present, in order, counter bit 1, counter bit 0, then stages 7 down to 0.
- R6: With `scan_en` = 1 and `load` = 0, every position takes the value of its lower neighbour and position 0 takes `scan_in`. The feedback is not applied.
- R7: With `scan_en` = 0, the counter increments by one modulo 4 on each clock. This happens whether or not `load` is high.
- R8: When the parameter `USE_DIN` is 0, `din` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Parallel seed load; takes precedence over scan and step |
| seed | input | 8 | Seed value, bit i goes to stage i |
| din | input | 1 | Data bit XORed into the feedback when `USE_DIN` = 1 |
| scan_en | input | 1 | Scan shift enable |
| scan_in | input | 1 | Serial input to chain position 0 |
| scan_out | output | 1 | Chain position 9 (counter bit 1) |
| keystream_bit | output | 1 | Stage 7 |

## Verification
The embedded properties assume that `rst` is asserted at the first edge, and that `load`, `scan_en`, `scan_in`, `seed` and `din` are stable around each rising edge. The property tying `scan_out` to `keystream_bit` two cycles earlier assumes the chain has exactly two counter bits.

The stimulus respects these assumptions. It holds reset for two cycles and changes inputs only mid-cycle. It sweeps every one of the 256 seeds, and combines `scan_en` with `load` on odd seeds to exercise load priority.

// File: rtl/lfsr_scan_pkg.sv
package lfsr_scan_pkg;

    localparam int unsigned STAGES    = 8;
    localparam int unsigned ARCH_BITS = 2;
    localparam int unsigned CHAIN_LEN = STAGES + ARCH_BITS;

    // Tap mask: bit i set means stage i feeds stage 0 (1 + x^3 + x^8).
    localparam logic [STAGES-1:0] DEFAULT_TAPS  = 8'h84;
    localparam logic [STAGES-1:0] DEFAULT_RESET = 8'h01;

    typedef enum logic [1:0] {
        OP_STEP  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2
    } stage_op_e;

    // Load outranks scan, scan outranks the normal step.
    function automatic stage_op_e pick_op(input logic load, input logic scan_en);
        if (load)
            return OP_LOAD;
        else if (scan_en)
            return OP_SHIFT;
        else
            return OP_STEP;
    endfunction

endpackage

// File: rtl/lfsr_scan_stages.sv
module lfsr_scan_stages
    import lfsr_scan_pkg::*;
#(
    parameter int unsigned       W         = STAGES,
    parameter logic [W-1:0]      TAPS      = DEFAULT_TAPS,
    parameter logic [W-1:0]      RESET_VAL = DEFAULT_RESET,
    parameter bit                USE_DIN   = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         din,
    input  logic         scan_en,
    input  logic         scan_in,
    output logic [W-1:0] state
);

    localparam logic DIN_MASK = USE_DIN;

    stage_op_e op;
    logic      fb;

    assign op = pick_op(load, scan_en);
    assign fb = (^(state & TAPS)) ^ (din & DIN_MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RESET_VAL;
        end else begin
            unique case (op)
                OP_LOAD:  state <= seed;
                OP_SHIFT: state <= {state[W-2:0], scan_in};
                default:  state <= {state[W-2:0], fb};
            endcase
        end
    end

    // R2: upper stages follow their lower neighbour whenever no load occurs
    p_neighbour_r2: assert property (@(posedge clk) disable iff (rst)
        !load |=> state[W-1:1] == $past(state[W-2:0]));

    // R4: load wins over scan and step
    p_seed_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> state == $past(seed));

    // R6: scan shifting feeds stage 0 from the serial input
    p_scanin_r6: assert property (@(posedge clk) disable iff (rst)
        (scan_en && !load) |=> state[0] == $past(scan_in));

endmodule

// File: rtl/lfsr_scan_arch.sv
module lfsr_scan_arch
    import lfsr_scan_pkg::*;
#(
    parameter int unsigned AW = ARCH_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scan_en,
    input  logic          shift_in,
    output logic [AW-1:0] arch
);

    always_ff @(posedge clk) begin
        if (rst)
            arch <= '0;
        else if (scan_en)
            arch <= {arch[AW-2:0], shift_in};
        else
            arch <= arch + AW'(1);
    end

    // R7: free-running count outside scan
    p_count_r7: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> arch == $past(arch) + AW'(1));

    // R5: the counter's low bit continues the chain after the last stage
    p_archshift_r5: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> arch[0] == $past(shift_in));

endmodule

// File: rtl/lfsr_scan_top.sv
module lfsr_scan_top
    import lfsr_scan_pkg::*;
#(
    parameter int unsigned       W         = STAGES,
    parameter int unsigned       AW        = ARCH_BITS,
    parameter logic [W-1:0]      TAPS      = DEFAULT_TAPS,
    parameter logic [W-1:0]      RESET_VAL = DEFAULT_RESET,
    parameter bit                USE_DIN   = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         din,
    input  logic         scan_en,
    input  logic         scan_in,
    output logic         scan_out,
    output logic         keystream_bit
);

    localparam int unsigned CHAIN = W + AW;

    logic [W-1:0]     state;
    logic [AW-1:0]    arch;
    logic [CHAIN-1:0] chain;

    lfsr_scan_stages #(
        .W(W), .TAPS(TAPS), .RESET_VAL(RESET_VAL), .USE_DIN(USE_DIN)
    ) u_stages (
        .clk(clk), .rst(rst), .load(load), .seed(seed), .din(din),
        .scan_en(scan_en), .scan_in(scan_in), .state(state)
    );

    lfsr_scan_arch #(.AW(AW)) u_arch (
        .clk(clk), .rst(rst), .scan_en(scan_en),
        .shift_in(state[W-1]), .arch(arch)
    );

    // Chain position k: stages at 0..W-1, counter bits above them.
    assign chain         = {arch, state};
    assign scan_out      = chain[CHAIN-1];
    assign keystream_bit = state[W-1];

    generate
        if (AW == 2) begin : g_chk_two
            // R5: a stage-7 bit reaches scan_out after two scan clocks
            p_scanout_r5: assert property (@(posedge clk) disable iff (rst)
                (scan_en ##1 scan_en) |=> scan_out == $past(keystream_bit, 2));
        end
    endgenerate

endmodule

// File: tb/lfsr_scan_top_tb.sv
module lfsr_scan_top_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load = 1'b0;
    logic [7:0] seed = '0;
    logic       din = 1'b0;
    logic       scan_en = 1'b0;
    logic       scan_in = 1'b0;
    logic       scan_out, keystream_bit;
    logic       p_scan_out, p_keystream_bit;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench-side reference state
    logic [7:0] ms, mp;
    logic [1:0] ma, map;

    always #5 clk = ~clk;

    lfsr_scan_top u_dut (
        .clk(clk), .rst(rst), .load(load), .seed(seed), .din(din),
        .scan_en(scan_en), .scan_in(scan_in),
        .scan_out(scan_out), .keystream_bit(keystream_bit)
    );

    lfsr_scan_top #(.USE_DIN(1'b0)) u_dut_plain (
        .clk(clk), .rst(rst), .load(load), .seed(seed), .din(din),
        .scan_en(scan_en), .scan_in(scan_in),
        .scan_out(p_scan_out), .keystream_bit(p_keystream_bit)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: advance the reference, then compare outputs mid-cycle.
    task automatic tick(input string req);
        @(posedge clk);
        if (rst) begin
            ms = 8'h01; mp = 8'h01; ma = 2'd0; map = 2'd0;
        end else begin
            ma  = scan_en ? {ma[0], ms[7]}  : ma + 2'd1;
            map = scan_en ? {map[0], mp[7]} : map + 2'd1;
            if (load) begin
                ms = seed; mp = seed;
            end else if (scan_en) begin
                ms = {ms[6:0], scan_in}; mp = {mp[6:0], scan_in};
            end else begin
                ms = {ms[6:0], ms[2] ^ ms[7] ^ din};
                mp = {mp[6:0], mp[2] ^ mp[7]};
            end
        end
        #2;
        chk({req, " keystream"}, 16'(keystream_bit), 16'(ms[7]));
        chk(scan_en ? "R5 scan_out" : "R7 scan_out", 16'(scan_out), 16'(ma[1]));
        chk("R8 plain keystream", 16'(p_keystream_bit), 16'(mp[7]));
        chk("R8 plain scan_out", 16'(p_scan_out), 16'(map[1]));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [9:0] vec;
        logic [9:0] exp_vec;
        logic [9:0] pat;

        tick("R1");
        tick("R1");
        chk("R1 reset keystream", 16'(keystream_bit), 16'd0);
        chk("R1 reset scan_out", 16'(scan_out), 16'd0);
        rst = 1'b0;

        // Full scan-out right after reset
        scan_en = 1'b1;
        vec = '0;
        for (int k = 0; k < 10; k++) begin
            vec = {vec[8:0], scan_out};
            scan_in = 1'b0;
            tick("R6");
        end
        chk("R1 reset vector", 16'(vec), 16'h001);

        for (int s = 0; s < 256; s++) begin
            // Load, with scan_en also high on odd seeds (R4 priority)
            seed = 8'(s);
            load = 1'b1;
            scan_en = seed[0];
            din = 1'b0;
            tick("R4");
            chk("R4 loaded stage 7", 16'(keystream_bit), 16'(seed[7]));
            load = 1'b0;
            scan_en = 1'b0;

            for (int j = 0; j < 12; j++) begin
                din = (j < 7) ? 1'b0 : (seed[j % 8] ^ j[0]);
                tick("R3");
                if (j < 7)
                    chk("R2 seed bit on keystream", 16'(keystream_bit), 16'(seed[6 - j]));
            end

            // Serial dump of the whole chain while a new pattern enters
            exp_vec = {ma, ms};
            pat = 10'(s * 37 + 5);
            scan_en = 1'b1;
            vec = '0;
            for (int k = 0; k < 10; k++) begin
                vec = {vec[8:0], scan_out};
                scan_in = pat[k];
                tick("R6");
            end
            chk("R5 chain vector", 16'(vec), 16'(exp_vec));

            // Stage 7 now holds pat[2]; stage 0 holds pat[9]
            chk("R6 scanned-in stage 7", 16'(keystream_bit), 16'(pat[2]));
            scan_en = 1'b0;
            scan_in = 1'b0;
            for (int j = 0; j < 8; j++) begin
                din = seed[j % 8];
                tick("R6");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule